// File: doc/BRIEF.md
# Sequential Radix-2 Integer Multiplier

This block multiplies two integer operands over a fixed number of clock cycles and leaves a double-width product split into a high word and a low word. A one-cycle `start` request captures the operands and a mode bit. The mode bit selects unsigned or two's-complement signed operation. While the operation runs, `busy` is high. When the product is ready, `done` pulses for one cycle and the result appears on `hi` and `lo`.

All iterations run in one double-width product register. At the start its upper half is cleared and its lower half is loaded with the multiplier operand. The multiplicand is held in a separate register that does not shift. Each cycle the block performs one addition, one subtraction or no arithmetic on the upper half, then shifts the whole register right by one bit. The bits of the multiplier leave at the bottom as the product grows in from the top.

In unsigned mode, the multiplicand is added whenever the bit at the bottom of the register is 1. In signed mode, the block uses Booth recoding: it compares the bottom bit with the bit shifted out in the previous cycle. A run of ones is handled with one subtraction where the run begins and one addition where it ends.

Top module: `seq_mult`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `busy` and `done` are 0 and `hi` and `lo` are all zeros.
- R2: When `signed_mode` = 0, the pair {`hi`,`lo`} equals the exact unsigned double-width product of `op_a` and `op_b`, including operands whose top bit is set.
- R3: When `signed_mode` = 1, {`hi`,`lo`} equals the two's-complement double-width product of `op_a` and `op_b`.
- R4: `done` is high after exactly WIDTH clock edges following the edge that accepts `start` (32 with the default WIDTH).
- R5: `done` is high for exactly one cycle. `hi` and `lo` change only on the edge that raises `done`, and they keep their values afterwards.
- R6: A `start` that arrives while `busy` is high is ignored. The running result and its completion time are unchanged, and no second operation follows.
- R7: `busy` rises on the edge after an accepted `start` and stays high until the edge that raises `done`. A `start` in the same cycle as `done` is accepted.
- R8: The signed extremes are exact. These are the most negative value multiplied by itself, by -1 and by the most positive value, and zero by anything.
- R9: With the example operands, unsigned 2 × 3 gives 6 and signed 2 × -3 gives all ones in `hi` and 0xFFFFFFFA in `lo`.
- R10: In unsigned mode no iteration ever subtracts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiplication; sampled only when idle |
| signed_mode | input | 1 | 1 = two's-complement signed operation, 0 = unsigned |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when the result is ready |
| hi | output | WIDTH | Upper half of the product |
| lo | output | WIDTH | Lower half of the product |

## Verification
Two events can fall in the same cycle. A new `start` can coincide with the `done` pulse of the previous operation, and it must be accepted without any gap. A `start` can also arrive in the middle of a run, and it must have no effect. The bench raises `start`, with different operands, on the exact negative edge where it sees `done`. It then checks that `busy` is high one edge later and that the second product arrives on time. In other runs it pulses `start` five cycles into the iteration with unrelated operands. It then checks that the product and the 32-edge latency match the first request, and that no further `done` follows.

// File: rtl/seq_mult_pkg.sv
package seq_mult_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ADD  = 2'd1,
    STEP_SUB  = 2'd2
  } step_op_e;
endpackage

// File: rtl/seq_mult_step.sv
module seq_mult_step
  import seq_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2*WIDTH-1:0] prod_cur,
  input  logic [WIDTH-1:0]   mcand,
  input  logic               signed_mode,
  input  logic               prev_bit,
  output step_op_e           op,
  output logic [2*WIDTH-1:0] prod_next
);
  localparam int EXT_W = WIDTH + 1;

  logic [WIDTH-1:0] upper;
  logic [EXT_W-1:0] upper_ext;
  logic [EXT_W-1:0] mcand_ext;
  logic [EXT_W-1:0] sum;
  logic             lsb;

  assign upper     = prod_cur[2*WIDTH-1:WIDTH];
  assign lsb       = prod_cur[0];
  // Signed mode widens by sign so the top bit of sum is the true sign.
  // Unsigned mode widens by zero so the top bit of sum is the carry.
  assign upper_ext = {signed_mode & upper[WIDTH-1], upper};
  assign mcand_ext = {signed_mode & mcand[WIDTH-1], mcand};

  always_comb begin
    op = STEP_HOLD;
    if (!signed_mode) begin
      if (lsb) op = STEP_ADD;
    end else begin
      unique case ({lsb, prev_bit})
        2'b10:   op = STEP_SUB;
        2'b01:   op = STEP_ADD;
        default: op = STEP_HOLD;
      endcase
    end
  end

  always_comb begin
    unique case (op)
      STEP_ADD: sum = upper_ext + mcand_ext;
      STEP_SUB: sum = upper_ext - mcand_ext;
      default:  sum = upper_ext;
    endcase
  end

  assign prod_next = {sum, prod_cur[WIDTH-1:1]};
endmodule

// File: rtl/seq_mult_ctrl.sv
module seq_mult_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic accept,
  output logic last_step
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] cnt;

  assign accept    = start & ~busy;
  assign last_step = busy & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last_step) busy <= 1'b0;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= LAST)) else $error("count out of range"); // R4
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy) else $error("busy not raised"); // R7
  AST_BUSY_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    last_step |=> !busy) else $error("busy did not end"); // R7
endmodule

// File: rtl/seq_mult.sv
module seq_mult
  import seq_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             signed_mode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  localparam int PROD_W = 2 * WIDTH;

  logic              accept;
  logic              last_step;
  logic [PROD_W-1:0] prod_q;
  logic [PROD_W-1:0] prod_next;
  logic [WIDTH-1:0]  mcand_q;
  logic              mode_q;
  logic              prev_q;
  step_op_e          op;

  seq_mult_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .accept    (accept),
    .last_step (last_step)
  );

  seq_mult_step #(.WIDTH(WIDTH)) u_step (
    .prod_cur    (prod_q),
    .mcand       (mcand_q),
    .signed_mode (mode_q),
    .prev_bit    (prev_q),
    .op          (op),
    .prod_next   (prod_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q  <= '0;
      mcand_q <= '0;
      mode_q  <= 1'b0;
      prev_q  <= 1'b0;
    end else if (accept) begin
      prod_q  <= {{WIDTH{1'b0}}, op_b};
      mcand_q <= op_a;
      mode_q  <= signed_mode;
      prev_q  <= 1'b0;
    end else if (busy) begin
      prod_q <= prod_next;
      prev_q <= prod_q[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      hi   <= '0;
      lo   <= '0;
    end else begin
      done <= last_step;
      if (last_step) begin
        hi <= prod_next[PROD_W-1:WIDTH];
        lo <= prod_next[WIDTH-1:0];
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R5
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy || $past(busy)) else $error("done without run"); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({hi, lo})) else $error("result moved without done"); // R5
  AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable({mcand_q, mode_q})) else $error("operands changed mid-run"); // R6
  AST_NO_SUB_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
    (busy && !mode_q) |-> (op != STEP_SUB)) else $error("subtract in unsigned mode"); // R10
endmodule

// File: tb/seq_mult_bench.sv
module seq_mult_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         signed_mode = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] hi;
  logic [W-1:0] lo;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  seq_mult #(.WIDTH(W)) u_seq_mult (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  function automatic logic [2*W-1:0] expect_prod(logic [W-1:0] a, logic [W-1:0] b, logic s);
    logic [2*W-1:0] ea, eb;
    ea = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    eb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ea * eb;
  endfunction

  task automatic check(bit ok, string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge where done is seen.
  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic s, bit poke, string req);
    int n;
    logic [2*W-1:0] exp;
    exp = expect_prod(a, b, s);
    op_a = a; op_b = b; signed_mode = s; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    op_a = $urandom; op_b = $urandom; signed_mode = ~s;
    check(busy == 1'b1, "R7 busy after accept", {63'd0, busy}, 64'd1);
    n = 0;
    while (n < 40) begin
      if (poke && n == 5) begin
        start = 1'b1; op_a = $urandom; op_b = $urandom;
      end
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      n++;
      if (done) break;
    end
    check(n == W, "R4 latency", 64'(n), 64'(W));
    check({hi, lo} == exp, req, {hi, lo}, exp);
    if (poke) check(n == W, "R6 start while busy ignored", 64'(n), 64'(W));
  endtask

  task automatic after_done(string req);
    logic [2*W-1:0] held;
    held = {hi, lo};
    @(negedge clk);
    check(done == 1'b0, "R5 done pulse width", {63'd0, done}, 64'd0);
    check({hi, lo} == held, req, {hi, lo}, held);
    check(busy == 1'b0, "R6 no second run", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check({busy, done, hi, lo} == '0, "R1 reset state", {hi, lo}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check({busy, done, hi, lo} == '0, "R1 after reset", {hi, lo}, 64'd0);

    run_op(32'd2, 32'd3, 1'b0, 1'b0, "R9 unsigned 2x3");
    after_done("R5 hold");
    run_op(32'd2, 32'hFFFF_FFFD, 1'b1, 1'b0, "R9 signed 2x-3");
    after_done("R5 hold");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R2 unsigned max");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R8 min x min");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R8 min x -1");
    run_op(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0, "R8 min x max");
    run_op(32'h0, 32'h8000_0000, 1'b1, 1'b0, "R8 zero x min");
    run_op(32'hAAAA_5555, 32'h0F0F_F0F0, 1'b1, 1'b1, "R6 product after mid-run start");
    after_done("R5 hold after poke");

    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      logic s;
      a = $urandom; b = $urandom; s = 1'($urandom);
      if (s) run_op(a, b, s, i % 7 == 3, "R3 signed random");
      else   run_op(a, b, s, i % 7 == 3, "R2 unsigned random");
      if (i % 4 == 0) after_done("R5 hold random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule